// File: doc/BRIEF.md
# Reference-Compare Prescaled Timer

This block is a 16-bit up-counting timer driven by a small register interface. Software programs a divisor, picks a clock source and writes a reference value. Once enabled, the counter advances on each prescaled tick. When the counter equals the reference value on a tick, a reference-reached event flag is set, and a level interrupt is raised if the mode register enables it. The counter then either returns to zero or holds at the reference value, depending on the restart bit.

The register port is synchronous. A write takes effect at the clock edge where `wr_en` is high. A read is combinational from `addr`. The byte offsets are 0x00 for mode, 0x04 for reference, 0x08 for capture, 0x0C for count and 0x11 for event.

The counting engine is a four-state machine:
- OFF: the enable bit is clear.
- HOLD: the timer is enabled but the clock source code is not usable.
- RUN: the timer is counting.
- DONE: a match occurred with restart disabled, and the counter is frozen at the reference value.

Transitions:
- Any write to mode or reference leaves the current state. So does a write to the count register. The target is OFF, HOLD or RUN, chosen by the mode that is in force after the write.
- RUN moves to DONE on a match tick when the restart bit is clear.
- RUN stays in RUN on a match tick when the restart bit is set.
- All other cases hold the current state.

Top module: `ref_timer`

## Requirements
- R1: After reset the mode, reference, capture, count and event registers all read 0, and `irq` is 0.
- R2: The counter advances only when mode bit 0 (enable) is 1 and mode bits 2:1 hold code 1 or code 2. With enable 0, or with code 0 or code 3, the count stays frozen.
- R3: Let D be mode bits 15:8. With code 1, one tick occurs every D+1 clocks. With code 2, one tick occurs every 16·(D+1) clocks. After a restarting write at edge E0, the count after edge E0+m equals floor(m / period).
- R4: On a tick where the count equals the reference value, event bit 1 is set. When mode bit 3 is 1, the count returns to 0 on that tick.
- R5: When mode bit 3 is 0, a match leaves the count at the reference value. Counting then stops until the next write to mode, reference or count.
- R6: The event register is at offset 0x11. Bit 1 is reference-reached and bit 0 is capture, which always reads 0. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R7: `irq` is a register that, one clock after each edge, equals mode bit 4 ANDed with event bit 1.
- R8: A mode write with bit 0 = 0 while the current mode bit 0 is 1 clears the reference register to 0. The mode register then takes the written value.
- R9: A write to mode or reference sets the count to 0 and restarts the prescaler phase.
- R10: A write to the count register (0x0C) loads the written value and restarts the prescaler phase. Counting then continues upward from that value, and a DONE state returns to RUN.
- R11: The capture register (0x08) reads back the last value written to it. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Registered reference interrupt level |

## Verification
A wrong prescaler phase shows up on the count register as an off-by-one tick, which the bench sees within one tick period of the restarting write. A wrong state-machine state shows up as a count that moves when it should hold, or holds when it should move. The clearest examples are a DONE state that keeps counting and a HOLD state that advances. A corrupted event flag or interrupt register is visible on `irq` one clock after the edge that caused it.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } tmr_state_e;

    localparam logic [4:0] OFS_MODE  = 5'h00;
    localparam logic [4:0] OFS_REFV  = 5'h04;
    localparam logic [4:0] OFS_CAPT  = 5'h08;
    localparam logic [4:0] OFS_COUNT = 5'h0C;
    localparam logic [4:0] OFS_EVENT = 5'h11;

    localparam int MB_EN   = 0;
    localparam int MB_SRCL = 1;
    localparam int MB_SRCH = 2;
    localparam int MB_WRAP = 3;
    localparam int MB_IEN  = 4;
    localparam int MB_DIVL = 8;

    function automatic logic src_usable(input logic [1:0] code);
        return (code == 2'd1) || (code == 2'd2);
    endfunction

endpackage

// File: rtl/ref_timer_prescaler.sv
module ref_timer_prescaler #(
    parameter int PRE_W = 8,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             sel_slow,
    input  logic [PRE_W-1:0] divisor,
    output logic             tick
);
    logic             base_stb;
    logic [PRE_W-1:0] pre_q;
    logic             pre_last;

    generate
        if (SUB_W > 0) begin : g_slow
            logic [SUB_W-1:0] sub_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sub_q <= '0;
                end else if (clr) begin
                    sub_q <= '0;
                end else if (run && sel_slow) begin
                    sub_q <= sub_q + 1'b1;
                end
            end
            assign base_stb = sel_slow ? (&sub_q) : 1'b1;
        end else begin : g_fast
            assign base_stb = 1'b1;
        end
    endgenerate

    assign pre_last = (pre_q == divisor);
    assign tick     = run && base_stb && pre_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run && base_stb) begin
            pre_q <= pre_last ? '0 : pre_q + 1'b1;
        end
    end

    // R3: the divide phase never passes the programmed divisor while running
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= divisor));

endmodule

// File: rtl/ref_timer_count_fsm.sv
module ref_timer_count_fsm
    import ref_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start_en,
    input  logic             start_usable,
    input  logic             wrap_on_ref,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             match
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             reseed;
    logic             hit;
    tmr_state_e       seed_state;

    assign reseed = restart || load;
    assign hit    = (state_q == ST_RUN) && tick && (cnt_q == ref_val) && !reseed;

    always_comb begin
        if (!start_en)          seed_state = ST_OFF;
        else if (!start_usable) seed_state = ST_HOLD;
        else                    seed_state = ST_RUN;
    end

    always_comb begin
        state_d = state_q;
        if (reseed) begin
            state_d = seed_state;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_HOLD: state_d = ST_HOLD;
                ST_RUN:  state_d = (hit && !wrap_on_ref) ? ST_DONE : ST_RUN;
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (state_q == ST_RUN && tick) begin
            if (hit) cnt_d = wrap_on_ref ? '0 : cnt_q;
            else     cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        running = (state_q == ST_RUN);
        match   = hit;
        count   = cnt_q;
    end

    // R2: outside RUN, with no write, the count is frozen
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !reseed) |=> $stable(cnt_q));

    // R9: a mode or reference write leaves the count at zero
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R5: DONE holds the count at the reference
    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wrap_on_ref) |=> (cnt_q == $past(ref_val)));

endmodule

// File: rtl/ref_timer_event.sv
module ref_timer_event (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic       clr_ref,
    input  logic       irq_en,
    output logic [1:0] flags,
    output logic       irq
);
    logic ref_flag_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_flag_q <= 1'b0;
        end else if (match) begin
            ref_flag_q <= 1'b1;
        end else if (clr_ref) begin
            ref_flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_en && ref_flag_q;
    end

    assign flags = {ref_flag_q, 1'b0};
    assign irq   = irq_q;

    // R4: a match always leaves the reference flag set
    p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> ref_flag_q);

    // R6: the flag only drops when software clears it
    p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_flag_q) |-> $past(clr_ref));

endmodule

// File: rtl/ref_timer.sv
module ref_timer
    import ref_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam int DIV_H = MB_DIVL + PRE_W - 1;

    logic [CNT_W-1:0] mode_q, refv_q, capt_q;
    logic             wr_mode, wr_refv, wr_capt, wr_count, wr_event;
    logic             restart, start_en, start_usable;
    logic             tick, running, match, disarm;
    logic [CNT_W-1:0] count;
    logic [1:0]       flags;

    assign wr_mode  = wr_en && (addr == OFS_MODE);
    assign wr_refv  = wr_en && (addr == OFS_REFV);
    assign wr_capt  = wr_en && (addr == OFS_CAPT);
    assign wr_count = wr_en && (addr == OFS_COUNT);
    assign wr_event = wr_en && (addr == OFS_EVENT);

    assign restart = wr_mode || wr_refv;
    assign disarm  = wr_mode && mode_q[MB_EN] && !wdata[MB_EN];

    always_comb begin
        if (wr_mode) begin
            start_en     = wdata[MB_EN];
            start_usable = src_usable(wdata[MB_SRCH:MB_SRCL]);
        end else begin
            start_en     = mode_q[MB_EN];
            start_usable = src_usable(mode_q[MB_SRCH:MB_SRCL]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            refv_q <= '0;
            capt_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (disarm)       refv_q <= '0;
            else if (wr_refv) refv_q <= wdata;
            if (wr_capt) capt_q <= wdata;
        end
    end

    ref_timer_prescaler #(.PRE_W(PRE_W), .SUB_W(SUB_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart || wr_count),
        .run      (running),
        .sel_slow (mode_q[MB_SRCH:MB_SRCL] == 2'd2),
        .divisor  (mode_q[DIV_H:MB_DIVL]),
        .tick     (tick)
    );

    ref_timer_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .load         (wr_count),
        .load_val     (wdata),
        .start_en     (start_en),
        .start_usable (start_usable),
        .wrap_on_ref  (mode_q[MB_WRAP]),
        .ref_val      (refv_q),
        .tick         (tick),
        .count        (count),
        .running      (running),
        .match        (match)
    );

    ref_timer_event u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .clr_ref (wr_event && wdata[1]),
        .irq_en  (mode_q[MB_IEN]),
        .flags   (flags),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_MODE:  rdata = mode_q;
            OFS_REFV:  rdata = refv_q;
            OFS_CAPT:  rdata = capt_q;
            OFS_COUNT: rdata = count;
            OFS_EVENT: rdata = {{(CNT_W-2){1'b0}}, flags};
            default:   rdata = '0;
        endcase
    end

    // R8: disabling a running timer wipes the reference
    p_disarm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (refv_q == '0));

    // R7: the interrupt needs the enable bit one cycle earlier
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mode_q[MB_IEN]));

    // R2: nothing counts while the enable bit is clear
    p_no_tick_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MB_EN] |-> !tick);

endmodule

// File: tb/ref_timer_bench.sv
`timescale 1ns/100ps
module ref_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = 5'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ref_timer u_ref_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic step(input int m);
        repeat (m) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        addr = a;
        #0.2;
        v = int'(rdata);
    endtask

    task automatic t_reset;
        int v;
        rd(5'h00, v); chk("R1 mode", v, 0);
        rd(5'h04, v); chk("R1 ref", v, 0);
        rd(5'h08, v); chk("R1 capture", v, 0);
        rd(5'h0C, v); chk("R1 count", v, 0);
        rd(5'h11, v); chk("R1 event", v, 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_basic;
        int v;
        wr(5'h04, 16'd5);
        wr(5'h00, 16'h001B);
        step(3); rd(5'h0C, v); chk("R3 count after 3", v, 3);
        step(2); rd(5'h0C, v); chk("R4 count at ref", v, 5);
        rd(5'h11, v); chk("R4 no event yet", v, 0);
        step(1); rd(5'h11, v); chk("R4 event set", v, 2);
        rd(5'h0C, v); chk("R4 wrap to zero", v, 0);
        chk("R7 irq lags flag", int'(irq), 0);
        step(1); chk("R7 irq high", int'(irq), 1);
        rd(5'h0C, v); chk("R4 counting again", v, 1);
        wr(5'h11, 16'h0002);
        rd(5'h11, v); chk("R6 cleared", v, 0);
        chk("R7 irq still high", int'(irq), 1);
        step(1); chk("R7 irq falls", int'(irq), 0);
    endtask

    task automatic t_prescale;
        int v;
        wr(5'h00, 16'h030B);
        rd(5'h04, v); chk("R8 ref kept when enable stays", v, 5);
        step(9); rd(5'h0C, v); chk("R3 div4 count", v, 2);
        step(3); rd(5'h0C, v); chk("R3 div4 count 12", v, 3);
        wr(5'h00, 16'h0105);
        step(63); rd(5'h0C, v); chk("R3 slow 63", v, 1);
        step(1); rd(5'h0C, v); chk("R3 slow 64", v, 2);
    endtask

    task automatic t_sources;
        int v;
        wr(5'h00, 16'h0001);
        step(40); rd(5'h0C, v); chk("R2 code0 frozen", v, 0);
        wr(5'h00, 16'h0007);
        step(40); rd(5'h0C, v); chk("R2 code3 frozen", v, 0);
        wr(5'h00, 16'h000A);
        rd(5'h04, v); chk("R8 ref cleared", v, 0);
        rd(5'h00, v); chk("R8 mode stored", v, 16'h000A);
        step(40); rd(5'h0C, v); chk("R2 disabled frozen", v, 0);
    endtask

    task automatic t_norestart;
        int v;
        wr(5'h11, 16'h0002);
        wr(5'h04, 16'd4);
        wr(5'h00, 16'h0013);
        step(5); rd(5'h11, v); chk("R5 event", v, 2);
        rd(5'h0C, v); chk("R5 at ref", v, 4);
        step(10); rd(5'h0C, v); chk("R5 holds", v, 4);
        chk("R7 irq", int'(irq), 1);
        wr(5'h11, 16'h0000);
        step(2); rd(5'h11, v); chk("R6 zero write no effect", v, 2);
        chk("R6 irq kept", int'(irq), 1);
        wr(5'h11, 16'h0001);
        rd(5'h11, v); chk("R6 capture bit write", v, 2);
        wr(5'h11, 16'h0002);
        rd(5'h11, v); chk("R6 clear", v, 0);
        step(1); chk("R7 irq low", int'(irq), 0);
        step(20); rd(5'h11, v); chk("R5 no re-set", v, 0);
        rd(5'h0C, v); chk("R5 still held", v, 4);
    endtask

    task automatic t_load;
        int v;
        wr(5'h0C, 16'd1);
        rd(5'h0C, v); chk("R10 loaded", v, 1);
        step(2); rd(5'h0C, v); chk("R10 continues", v, 3);
        step(2); rd(5'h11, v); chk("R10 reaches ref", v, 2);
        rd(5'h0C, v); chk("R10 held", v, 4);
        wr(5'h11, 16'h0002);
    endtask

    task automatic t_restart;
        int v;
        wr(5'h00, 16'h030B);
        step(7); rd(5'h0C, v); chk("R9 pre", v, 1);
        wr(5'h04, 16'd9);
        rd(5'h0C, v); chk("R9 ref write zero", v, 0);
        step(3); rd(5'h0C, v); chk("R9 phase restarted", v, 0);
        step(1); rd(5'h0C, v); chk("R9 first tick", v, 1);
    endtask

    task automatic t_mask;
        int v;
        wr(5'h04, 16'd2);
        wr(5'h00, 16'h000B);
        step(5); rd(5'h11, v); chk("R4 flag", v, 2);
        chk("R7 masked", int'(irq), 0);
        wr(5'h00, 16'h001B);
        chk("R7 not yet", int'(irq), 0);
        step(1); chk("R7 unmasked", int'(irq), 1);
    endtask

    task automatic t_capture;
        int v;
        wr(5'h08, 16'hBEEF);
        rd(5'h08, v); chk("R11 capture", v, 16'hBEEF);
        rd(5'h10, v); chk("R11 unmapped 10", v, 0);
        rd(5'h14, v); chk("R11 unmapped 14", v, 0);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20;
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_basic;
        t_prescale;
        t_sources;
        t_norestart;
        t_load;
        t_restart;
        t_mask;
        t_capture;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule